// File: doc/BRIEF.md
# Invalidation Queue Descriptor Processor

This block drains a circular queue of 16-byte invalidation descriptors that software places in memory. Software programs the queue base and size, then advances a tail index. The engine keeps its own head index and fetches one descriptor at a time, from head toward tail, through a request/acknowledge read port. It decodes each descriptor's type.

A wait descriptor can post a 32-bit status word through a status-write port, request a completion event, or both. An interrupt-entry-cache descriptor retires with no side effect. Any other type is treated as malformed. On a malformed descriptor the engine stops with the head left on that descriptor and raises a sticky queue-error flag. It fetches nothing more until software clears the flag, and then it resumes from the same head.

Top module: `invq_engine`

## Requirements
- R1: After reset the queue address, tail, head and queue-error flag read as zero, and `dr_req`, `sw_req` and `evt_req` are low.
- R2: A write to the queue address register (select 0) holds the size code QS in bits 2:0 and the 4 KB-aligned base in bits ADDR_W-1:12. The write is dropped if any of bits 11:3 is set or any bit at or above ADDR_W is set.
- R3: The tail register (select 1) takes its index from bits 18:4 of the written value. The write is dropped if any other bit is set, or if the index is not below the entry count 2^(BASE_ORDER+QS).
- R4: While head differs from tail and no error is pending, descriptors are fetched one per read handshake at byte address base + 16*head. The head moves one slot, modulo the entry count, after each descriptor completes. Nothing is fetched when head equals tail.
- R5: The type is bits 3:0 of the low quadword. Type 4 retires with no status write and no event.
- R6: For type 5, if bit 5 of the low quadword is set, the engine makes one status write. The data is bits 63:32 of the low quadword. The address is the high quadword with bits 1:0 cleared, truncated to ADDR_W bits. The head advances after `sw_ack`.
- R7: For type 5, if bit 4 of the low quadword is set, `evt_req` pulses high for exactly one cycle.
- R8: Any type other than 4 or 5 stops processing with the head left at the faulting index and sets the queue-error flag. The flag is bit 4 of the fault status register (select 3).
- R9: While the queue-error flag is set, no descriptor is fetched, even after further tail writes.
- R10: Writing the fault status register with bit 4 set clears the flag, and processing resumes from the current head. A write with bit 4 clear leaves the flag unchanged.
- R11: `reg_rdata` is registered and shows the register chosen by `reg_sel` one cycle earlier. Head (select 2) and tail read with the index in bits 18:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 queue address, 1 tail, 2 head, 3 fault status |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Registered read data |
| dr_req | output | 1 | Descriptor read request, held until acknowledged |
| dr_addr | output | ADDR_W | Descriptor byte address |
| dr_ack | input | 1 | Descriptor read acknowledge, data valid |
| dr_data | input | 128 | Descriptor contents, low quadword in bits 63:0 |
| sw_req | output | 1 | Status write request, held until acknowledged |
| sw_addr | output | ADDR_W | Status write byte address |
| sw_data | output | 32 | Status write data |
| sw_ack | input | 1 | Status write acknowledge |
| evt_req | output | 1 | One-cycle completion event request |

## Verification
The bench builds the engine with BASE_ORDER = 2 and ADDR_W = 20. QS codes 0 to 3 then give queues of 4 to 32 entries, so wrap-around is reached in every size within a few hundred cycles. The bench sweeps several head-to-tail distances for each size, including zero and out-of-range tails. The 20-bit address width makes the rejection of high queue-address bits and the truncation of the status address observable. The bench places each of the sixteen type codes in turn at the head. This separates the two retiring types from every faulting one and exercises the stop/clear/resume path for each.

// File: rtl/invq_pkg.sv
package invq_pkg;
  localparam int IDX_W = 15;
  localparam logic [63:0] IDX_FIELD = 64'h7FFF0;
  localparam logic [3:0] T_IEC  = 4'd4;
  localparam logic [3:0] T_WAIT = 4'd5;

  localparam logic [1:0] SEL_QADDR = 2'd0;
  localparam logic [1:0] SEL_TAIL  = 2'd1;
  localparam logic [1:0] SEL_HEAD  = 2'd2;
  localparam logic [1:0] SEL_FAULT = 2'd3;

  typedef enum logic [1:0] {D_NOP, D_WAIT, D_BAD} dkind_e;
  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_STATUS} wstate_e;

  typedef struct packed {
    dkind_e      kind;
    logic        want_status;
    logic        want_event;
    logic [31:0] sdata;
    logic [63:0] saddr;
  } dinfo_t;
endpackage

// File: rtl/invq_decode.sv
module invq_decode
  import invq_pkg::*;
(
  input  logic [127:0] desc,
  output dinfo_t       info
);
  logic [3:0] ty;
  assign ty = desc[3:0];

  always_comb begin
    info.sdata       = desc[63:32];
    info.saddr       = {desc[127:66], 2'b00};
    info.want_status = 1'b0;
    info.want_event  = 1'b0;
    if (ty == T_IEC) begin
      info.kind = D_NOP;
    end else if (ty == T_WAIT) begin
      info.kind        = D_WAIT;
      info.want_status = desc[5];
      info.want_event  = desc[4];
    end else begin
      info.kind = D_BAD;
    end
  end
endmodule

// File: rtl/invq_regs.sv
module invq_regs
  import invq_pkg::*;
#(
  parameter int ADDR_W     = 39,
  parameter int BASE_ORDER = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [63:0]       wdata,
  input  logic [IDX_W-1:0]  head,
  input  logic              err_set,
  output logic [ADDR_W-13:0] base,
  output logic [IDX_W-1:0]  idx_mask,
  output logic [IDX_W-1:0]  tail,
  output logic              qerr,
  output logic [63:0]       rdata
);
  localparam logic [63:0] ADDR_KEEP = (64'd1 << ADDR_W) - 64'd1;

  logic [ADDR_W-1:0] qaddr_q;
  logic [2:0]        qs;
  logic [IDX_W:0]    entries;
  logic              qaddr_ok, tail_ok;

  assign qs       = qaddr_q[2:0];
  assign base     = qaddr_q[ADDR_W-1:12];
  assign entries  = (IDX_W+1)'(1) << (BASE_ORDER + int'(qs));
  assign idx_mask = IDX_W'(entries - (IDX_W+1)'(1));

  assign qaddr_ok = (wdata[11:3] == 9'd0) && ((wdata & ~ADDR_KEEP) == 64'd0);
  assign tail_ok  = ((wdata & ~IDX_FIELD) == 64'd0) &&
                    ({1'b0, wdata[18:4]} < entries);

  always_ff @(posedge clk) begin
    if (rst) begin
      qaddr_q <= '0;
      tail    <= '0;
      qerr    <= 1'b0;
      rdata   <= '0;
    end else begin
      if (we && sel == SEL_QADDR && qaddr_ok) qaddr_q <= wdata[ADDR_W-1:0];
      if (we && sel == SEL_TAIL && tail_ok)   tail    <= wdata[18:4];
      if (err_set)
        qerr <= 1'b1;
      else if (we && sel == SEL_FAULT && wdata[4])
        qerr <= 1'b0;
      case (sel)
        SEL_QADDR: rdata <= 64'(qaddr_q);
        SEL_TAIL:  rdata <= 64'({tail, 4'b0000});
        SEL_HEAD:  rdata <= 64'({head, 4'b0000});
        default:   rdata <= 64'({qerr, 4'b0000});
      endcase
    end
  end

  // R2: a write touching reserved bits leaves the queue address alone
  p_qaddr_rsvd_kept_r2: assert property (@(posedge clk) disable iff (rst)
    we && sel == SEL_QADDR && (wdata[11:3] != 9'd0) |=> $stable(qaddr_q));
  // R3: a tail write with bits outside the index field is dropped
  p_tail_rsvd_kept_r3: assert property (@(posedge clk) disable iff (rst)
    we && sel == SEL_TAIL && ((wdata & ~IDX_FIELD) != 64'd0) |=> $stable(tail));
  // R10: the error flag is sticky until a write with bit 4 set
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    qerr && !(we && sel == SEL_FAULT && wdata[4]) |=> qerr);
endmodule

// File: rtl/invq_walker.sv
module invq_walker
  import invq_pkg::*;
#(
  parameter int ADDR_W = 39
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-13:0] base,
  input  logic [IDX_W-1:0]   idx_mask,
  input  logic [IDX_W-1:0]   tail,
  input  logic               qerr_i,
  output logic [IDX_W-1:0]   head_o,
  output logic               dr_req_o,
  output logic [ADDR_W-1:0]  dr_addr_o,
  input  logic               dr_ack_i,
  input  logic [127:0]       dr_data_i,
  output logic               sw_req_o,
  output logic [ADDR_W-1:0]  sw_addr_o,
  output logic [31:0]        sw_data_o,
  input  logic               sw_ack_i,
  output logic               evt_req_o,
  output logic               err_set_o
);
  wstate_e           st;
  dinfo_t            info;
  logic [IDX_W-1:0]  nxt;
  logic [ADDR_W-1:0] slot_addr;

  invq_decode u_dec (.desc(dr_data_i), .info(info));

  assign nxt       = (head_o + IDX_W'(1)) & idx_mask;
  assign slot_addr = {base, 12'h000} + ADDR_W'({head_o, 4'b0000});

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      head_o    <= '0;
      dr_req_o  <= 1'b0;
      dr_addr_o <= '0;
      sw_req_o  <= 1'b0;
      sw_addr_o <= '0;
      sw_data_o <= '0;
      evt_req_o <= 1'b0;
      err_set_o <= 1'b0;
    end else begin
      evt_req_o <= 1'b0;
      err_set_o <= 1'b0;
      case (st)
        W_IDLE: begin
          if (!qerr_i && !err_set_o && head_o != tail) begin
            dr_req_o  <= 1'b1;
            dr_addr_o <= slot_addr;
            st        <= W_FETCH;
          end
        end
        W_FETCH: begin
          if (dr_ack_i) begin
            dr_req_o <= 1'b0;
            case (info.kind)
              D_NOP: begin
                head_o <= nxt;
                st     <= W_IDLE;
              end
              D_WAIT: begin
                evt_req_o <= info.want_event;
                if (info.want_status) begin
                  sw_req_o  <= 1'b1;
                  sw_addr_o <= info.saddr[ADDR_W-1:0];
                  sw_data_o <= info.sdata;
                  st        <= W_STATUS;
                end else begin
                  head_o <= nxt;
                  st     <= W_IDLE;
                end
              end
              default: begin
                err_set_o <= 1'b1;
                st        <= W_IDLE;
              end
            endcase
          end
        end
        default: begin
          if (sw_ack_i) begin
            sw_req_o <= 1'b0;
            head_o   <= nxt;
            st       <= W_IDLE;
          end
        end
      endcase
    end
  end

  // R4: a read request stays up with a steady address until acknowledged
  p_fetch_held_r4: assert property (@(posedge clk) disable iff (rst)
    dr_req_o && !dr_ack_i |=> dr_req_o && $stable(dr_addr_o));
  // R9: no fetch starts while the error flag is up
  p_no_fetch_in_error_r9: assert property (@(posedge clk) disable iff (rst)
    qerr_i && !dr_req_o |=> !dr_req_o);
  // R8: the head does not move on a faulting descriptor
  p_head_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    err_set_o |-> $stable(head_o));
  // R7: completion event is a single-cycle pulse
  p_evt_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    evt_req_o |=> !evt_req_o);
  // R6: status writes are word aligned
  p_status_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    sw_req_o |-> sw_addr_o[1:0] == 2'b00);
endmodule

// File: rtl/invq_engine.sv
module invq_engine
  import invq_pkg::*;
#(
  parameter int ADDR_W     = 39,
  parameter int BASE_ORDER = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              dr_req,
  output logic [ADDR_W-1:0] dr_addr,
  input  logic              dr_ack,
  input  logic [127:0]      dr_data,
  output logic              sw_req,
  output logic [ADDR_W-1:0] sw_addr,
  output logic [31:0]       sw_data,
  input  logic              sw_ack,
  output logic              evt_req
);
  logic [ADDR_W-13:0] base;
  logic [IDX_W-1:0]   idx_mask, tail, head;
  logic               qerr, err_set;

  invq_regs #(.ADDR_W(ADDR_W), .BASE_ORDER(BASE_ORDER)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .head(head), .err_set(err_set), .base(base), .idx_mask(idx_mask),
    .tail(tail), .qerr(qerr), .rdata(reg_rdata)
  );

  invq_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst(rst), .base(base), .idx_mask(idx_mask), .tail(tail),
    .qerr_i(qerr), .head_o(head), .dr_req_o(dr_req), .dr_addr_o(dr_addr),
    .dr_ack_i(dr_ack), .dr_data_i(dr_data), .sw_req_o(sw_req),
    .sw_addr_o(sw_addr), .sw_data_o(sw_data), .sw_ack_i(sw_ack),
    .evt_req_o(evt_req), .err_set_o(err_set)
  );

  // R1: nothing is requested in the cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> !dr_req && !sw_req && !evt_req);
endmodule

// File: tb/invq_engine_test.sv
module invq_engine_test;
  localparam int AW = 20;
  localparam int BO = 2;
  localparam logic [63:0] BASE = 64'h3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic dr_req, sw_req, evt_req;
  logic [AW-1:0] dr_addr, sw_addr;
  logic dr_ack = 1'b0, sw_ack = 1'b0;
  logic [127:0] dr_data = '0;
  logic [31:0] sw_data;

  logic [127:0] mem [0:63];
  int fetches = 0, sw_cnt = 0, evt_cnt = 0;
  logic [AW-1:0] sw_last_a = '0;
  logic [31:0] sw_last_d = '0;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;

  invq_engine #(.ADDR_W(AW), .BASE_ORDER(BO)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dr_req(dr_req),
    .dr_addr(dr_addr), .dr_ack(dr_ack), .dr_data(dr_data), .sw_req(sw_req),
    .sw_addr(sw_addr), .sw_data(sw_data), .sw_ack(sw_ack), .evt_req(evt_req)
  );

  always @(posedge clk) begin
    dr_ack  <= dr_req && !dr_ack;
    dr_data <= mem[6'((dr_addr - AW'(BASE)) >> 4)];
    if (dr_req && dr_ack) fetches <= fetches + 1;
    sw_ack <= sw_req && !sw_ack;
    if (sw_req && sw_ack) begin
      sw_cnt    <= sw_cnt + 1;
      sw_last_a <= sw_addr;
      sw_last_d <= sw_data;
    end
    if (evt_req) evt_cnt <= evt_cnt + 1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] v);
    @(negedge clk);
    reg_sel = s;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int mhead, cnt, f0, s0, e0, h;
    for (int i = 0; i < 64; i++) mem[i] = 128'h4;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 dr_req", 64'(dr_req), 0);
    chk("R1 sw_req", 64'(sw_req), 0);
    chk("R1 evt_req", 64'(evt_req), 0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1 reg reset / R11", v, 0);
    end

    // R2 queue address acceptance
    wr(0, BASE | 64'd1);        rd(0, v); chk("R2 valid", v, BASE | 64'd1);
    wr(0, BASE | 64'h8);        rd(0, v); chk("R2 bit3 reserved", v, BASE | 64'd1);
    wr(0, BASE | 64'h800);      rd(0, v); chk("R2 bit11 reserved", v, BASE | 64'd1);
    wr(0, (64'd1 << AW) | BASE); rd(0, v); chk("R2 high addr bit", v, BASE | 64'd1);
    wr(0, 64'h5002);            rd(0, v); chk("R2 valid2", v, 64'h5002);
    wr(0, BASE);                rd(0, v); chk("R2 restore", v, BASE);

    // R3 tail acceptance with QS=0 (4 entries)
    wr(1, 64'h31);      rd(1, v); chk("R3 low bit", v, 0);
    wr(1, 64'h40);      rd(1, v); chk("R3 idx==count", v, 0);
    wr(1, 64'h80000);   rd(1, v); chk("R3 bit19", v, 0);
    chk("R3 no fetch", 64'(fetches), 0);

    // R4 sweep of sizes and distances, wrap included
    mhead = 0;
    for (int qs = 0; qs < 4; qs++) begin
      cnt = 1 << (BO + qs);
      wr(0, BASE | 64'(qs));
      for (int k = 0; k < 6; k++) begin
        int step, t;
        step = (k * 5 + qs) % cnt;
        t = (mhead + step) % cnt;
        f0 = fetches;
        wr(1, 64'(t) << 4);
        idle(300);
        rd(2, v); chk("R4 head reaches tail", v, 64'(t) << 4);
        rd(1, v); chk("R11 tail readback", v, 64'(t) << 4);
        chk("R4 fetch count", 64'(fetches - f0), 64'(step));
        mhead = t;
      end
      wr(1, 64'(cnt) << 4);
      rd(1, v); chk("R3 out of range tail", v, 64'(mhead) << 4);
    end

    // R6/R7 wait descriptors (32 entries now)
    cnt = 32;
    h = mhead;
    mem[h] = {64'h12347, 32'hA5A50000 + 32'(h), 24'h0, 8'h35};
    s0 = sw_cnt; e0 = evt_cnt;
    wr(1, 64'((h + 1) % cnt) << 4);
    idle(100);
    chk("R6 one status write", 64'(sw_cnt - s0), 1);
    chk("R6 status addr", 64'(sw_last_a), 64'h12344);
    chk("R6 status data", 64'(sw_last_d), 64'(32'hA5A50000 + 32'(h)));
    chk("R7 event", 64'(evt_cnt - e0), 1);
    rd(2, v); chk("R6 head after ack", v, 64'((h + 1) % cnt) << 4);
    mem[h] = 128'h4;
    h = (h + 1) % cnt;
    mem[h] = {64'h0, 32'h0, 32'h15};
    mem[(h + 1) % cnt] = {64'h0, 32'h0, 32'h05};
    mem[(h + 2) % cnt] = {64'hFFFFF, 32'h12345678, 32'h25};
    s0 = sw_cnt; e0 = evt_cnt;
    wr(1, 64'((h + 3) % cnt) << 4);
    idle(150);
    chk("R6 only flagged write", 64'(sw_cnt - s0), 1);
    chk("R6 truncated addr", 64'(sw_last_a), 64'hFFFFC);
    chk("R6 data2", 64'(sw_last_d), 64'h12345678);
    chk("R7 only flagged event", 64'(evt_cnt - e0), 1);
    mem[h] = 128'h4; mem[(h + 1) % cnt] = 128'h4; mem[(h + 2) % cnt] = 128'h4;
    h = (h + 3) % cnt;

    // R8/R9/R10 fault, block, ignore, resume
    mem[(h + 1) % cnt] = 128'h7;
    f0 = fetches;
    wr(1, 64'((h + 3) % cnt) << 4);
    idle(100);
    rd(2, v); chk("R8 head frozen", v, 64'((h + 1) % cnt) << 4);
    rd(3, v); chk("R8 error flag bit4", v, 64'h10);
    chk("R8 fetch stops", 64'(fetches - f0), 2);
    f0 = fetches;
    wr(1, 64'((h + 5) % cnt) << 4);
    idle(100);
    chk("R9 no fetch in error", 64'(fetches - f0), 0);
    rd(2, v); chk("R9 head held", v, 64'((h + 1) % cnt) << 4);
    wr(3, 64'hEF);
    idle(50);
    rd(3, v); chk("R10 bit4 clear write ignored", v, 64'h10);
    chk("R10 still blocked", 64'(fetches - f0), 0);
    mem[(h + 1) % cnt] = 128'h4;
    wr(3, 64'h10);
    idle(150);
    rd(3, v); chk("R10 flag cleared", v, 0);
    rd(2, v); chk("R10 resumed to tail", v, 64'((h + 5) % cnt) << 4);
    chk("R10 resume fetches", 64'(fetches - f0), 4);
    h = (h + 5) % cnt;

    // R5/R8 every type code at the head
    for (int ty = 0; ty < 16; ty++) begin
      bit good;
      good = (ty == 4) || (ty == 5);
      mem[h] = 128'(ty);
      s0 = sw_cnt; e0 = evt_cnt;
      wr(1, 64'((h + 1) % cnt) << 4);
      idle(60);
      rd(2, v);
      chk("R5/R8 type head", v, 64'(good ? (h + 1) % cnt : h) << 4);
      rd(3, v);
      chk("R5/R8 type flag", v, good ? 64'h0 : 64'h10);
      chk("R5 no side effects", 64'((sw_cnt - s0) + (evt_cnt - e0)), 0);
      if (!good) begin
        mem[h] = 128'h4;
        wr(3, 64'h10);
        idle(60);
        rd(2, v); chk("R10 resume per type", v, 64'((h + 1) % cnt) << 4);
      end
      mem[h] = 128'h4;
      h = (h + 1) % cnt;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule